// File: doc/BRIEF.md
# High-Cycle Accumulation Timer

This block measures how many system clock cycles it takes for an input to spend a set number of clock cycles high. Each clock cycle in which the synchronised input is high counts as one "high", whether or not it belongs to the same pulse as the one before. Counting begins at the first rising edge of the input after the block is enabled. From that point an elapsed counter advances on every clock, and a high counter advances on every clock in which the input is high.

When the high counter reaches the threshold, the elapsed count, including the current cycle, is latched as the result and an event flag is raised. Both counters then restart at once. The measurement runs without stopping: a result that is never acknowledged is overwritten by the next one. The block suits duty-type monitoring, where the result divided into the threshold gives the high fraction over a window.

The input passes through two synchroniser flops, followed by one more flop for edge detection. Dropping the enable returns the whole cell to its idle state.

Top module: `hightime_timer`

## Requirements
- R1: Input `a_in` passes through two synchroniser flops. A level driven on `a_in` takes part in counting at the third rising clock edge after it is applied. For example, with threshold 1, `evt` is low after two edges and high after the third.
- R2: While enabled, no counting happens until the synchronised input shows a low-to-high transition. An input that is already high when `en` rises does not start a measurement.
- R3: Once started, the high counter counts single clock cycles in which the synchronised input is high, not whole pulses. With a pattern of H high cycles in each period of P cycles that begins with a high, the first result after start is ((X-1)/H)*P + ((X-1)%H) + 1.
- R4: On the clock in which the X-th high is counted, `result` takes the elapsed count including that clock, and both counters restart from zero on the next clock.
- R5: `evt` is set when a result is written. It stays set until `ack` is high on a clock with no new result, or until `en` is low. A new result in the same clock as `ack` keeps `evt` set. Acknowledging does not change `result`.
- R6: Leaving `evt` unacknowledged never stalls measurement. Later results overwrite `result` while `evt` stays high.
- R7: With the input held high after start, every result equals the threshold.
- R8: Reset, or `en` low for one clock, clears the start state, both counters, `result` and `evt`.
- R9: A threshold of 0 behaves as a threshold of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; low clears the cell |
| a_in | input | 1 | Asynchronous measured input |
| thresh | input | W | High-cycle threshold X |
| ack | input | 1 | Clears the event flag |
| result | output | W | Elapsed clocks for the last completed measurement |
| evt | output | 1 | Result-ready flag |

## Verification
A level applied to `a_in` first counts at the third rising edge. A result and its flag therefore appear three edges after the input cycle that completes the threshold. The bench drives inputs on falling edges and samples outputs on the falling edge before each new drive, so it sees every registered update one edge after the edge that makes it. The latency check samples `evt` exactly two and three edges after a high is applied. Clearing by `en` and `ack` is checked one edge after the control is driven. Pattern results are taken at the first falling edge where `evt` is seen high.

// File: rtl/hightime_timer.sv
module hightime_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         a_in,
  input  logic [W-1:0] thresh,
  input  logic         ack,
  output logic [W-1:0] result,
  output logic         evt
);

  logic [2:0]   a_pipe;
  logic         started;
  logic [W-1:0] cnt_t, cnt_h;

  wire          a_s       = a_pipe[1];
  wire          rise      = a_pipe[1] & ~a_pipe[2];
  wire [W-1:0]  thr_eff   = (thresh == '0) ? W'(1) : thresh;
  wire          start_now = en & ~started & rise;
  wire          running   = en & (started | start_now);
  wire [W-1:0]  h_next    = cnt_h + W'(1);
  wire          hit       = running & a_s & (h_next == thr_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) a_pipe <= '0;
    else        a_pipe <= {a_pipe[1:0], a_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      started <= 1'b0;
      cnt_t   <= '0;
      cnt_h   <= '0;
      result  <= '0;
      evt     <= 1'b0;
    end else begin
      if (start_now) started <= 1'b1;
      if (hit) begin
        result <= cnt_t + W'(1);
        cnt_t  <= '0;
        cnt_h  <= '0;
      end else if (running) begin
        cnt_t <= cnt_t + W'(1);
        if (a_s) cnt_h <= h_next;
      end
      if (hit)      evt <= 1'b1;
      else if (ack) evt <= 1'b0;
    end
  end

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (result == '0 && !evt && !started && cnt_t == '0));

  a_r5_ack_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack && !hit) |=> !evt);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt && !ack) |=> evt);

  a_r3_highs_within_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_h <= cnt_t);

  a_r2_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (cnt_t == '0 && cnt_h == '0));

  a_r4_result_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> result != '0);

endmodule

// File: tb/hightime_timer_bench.sv
module hightime_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, en = 1'b0, a_in = 1'b0, ack = 1'b0;
  logic [31:0] thresh = 32'd1;
  logic [31:0] result;
  logic        evt;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] kept;

  always #4 clk = ~clk;

  hightime_timer #(.W(32)) u_hightime_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a_in), .thresh(thresh),
    .ack(ack), .result(result), .evt(evt));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cell(input logic [31:0] x);
    en = 1'b0; a_in = 1'b0; ack = 1'b0; thresh = x;
    cyc(4);
    en = 1'b1;
    cyc(1);
  endtask

  task automatic run_pattern(input int h, input int p, input int x, input string tag);
    bit seen = 0;
    int expv = ((x - 1) / h) * p + ((x - 1) % h) + 1;
    clear_cell(x);
    for (int t = 0; t < 300 && !seen; t++) begin
      if (evt) begin
        seen = 1;
        check(result == expv, tag, result, expv);
      end else begin
        a_in = ((t % p) < h);
        @(negedge clk);
      end
    end
    if (!seen) check(1'b0, {tag, " no event"}, 0, expv);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 0 && evt == 0, "R8 reset state", {result, evt}, 0);

    // R1 latency with X=1
    clear_cell(1);
    a_in = 1'b1;
    cyc(2);
    check(evt == 0, "R1 evt after two edges", evt, 0);
    cyc(1);
    check(evt == 1 && result == 1, "R1 evt after three edges", evt, 1);

    // R8 enable low clears
    en = 1'b0;
    cyc(1);
    check(evt == 0 && result == 0, "R8 en low clears", {result, evt}, 0);

    // R2 input high at enable does not start
    en = 1'b0; a_in = 1'b1; thresh = 4;
    cyc(4);
    en = 1'b1;
    cyc(12);
    check(evt == 0, "R2 no start without rising edge", evt, 0);
    a_in = 1'b0;
    cyc(3);
    a_in = 1'b1;
    while (!evt) cyc(1);
    check(result == 4, "R2 R7 first result after rise", result, 4);

    // R5 set wins over simultaneous ack, X=1 held high
    clear_cell(1);
    a_in = 1'b1;
    cyc(4);
    ack = 1'b1;
    cyc(3);
    check(evt == 1, "R5 new result beats ack", evt, 1);
    ack = 1'b0;

    // R7 held high, two consecutive results
    clear_cell(5);
    a_in = 1'b1;
    while (!evt) cyc(1);
    check(result == 5, "R7 held high first", result, 5);
    ack = 1'b1; cyc(1); ack = 1'b0;
    check(evt == 0, "R5 ack clears flag", evt, 0);
    while (!evt) cyc(1);
    check(result == 5, "R7 held high second", result, 5);

    // R9 threshold zero
    clear_cell(0);
    a_in = 1'b1;
    cyc(3);
    check(evt == 1 && result == 1, "R9 zero acts as one", result, 1);

    // R6 overwrite without ack: X=2, alternating starting high
    clear_cell(2);
    for (int t = 0; t < 40; t++) begin
      if (t == 8) check(evt == 1 && result == 3, "R6 first result", result, 3);
      a_in = t[0] ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    check(evt == 1 && result == 4, "R6 overwritten result, flag held", result, 4);

    // R5 ack keeps result; input held low so no new result
    a_in = 1'b0;
    cyc(5);
    kept = result;
    ack = 1'b1; cyc(1); ack = 1'b0;
    check(evt == 0, "R5 ack clears flag with low input", evt, 0);
    check(result == kept, "R5 ack keeps result", result, kept);
    cyc(10);
    check(evt == 0, "R5 no event with low input", evt, 0);

    // R3 R4 sweep of high-cycle patterns
    for (int h = 1; h <= 3; h++)
      for (int p = h + 1; p <= h + 3; p++)
        for (int x = 1; x <= 6; x++)
          run_pattern(h, p, x, $sformatf("R3 R4 h=%0d p=%0d x=%0d", h, p, x));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule